// File: doc/BRIEF.md
# Banked SRAM Window Decoder

This block sits between a console's 16-bit processor bus and a 512K byte static RAM on a cartridge. It runs the cartridge's default bank-switching mode. A 16K window at $4000-$7FFF shows one of 32 banks of the SRAM. The bank is picked by a register that the console writes at $0510. A fixed 2K window at $3800-$3FFF always shows the topmost 2K of the same SRAM, whatever bank is selected. The block also decodes a 16-byte register range at $0500-$050F for an external sound chip.

A second controller on the board supplies two enables. The RAM enable is active low and the sound enable is active high. Each final chip select is the AND of this block's own decode and the matching enable. The bus direction line chooses output enable on reads and write enable on writes. Write enable is further limited to the bus phase in which write data is valid. Address decode and the strobes are combinational from the bus pins. Only the bank register is clocked: it captures on the rising clock edge while a valid write to $0510 is presented.

Top module: `sram_win_dec`

## Requirements
- R1: An access in $4000-$7FFF drives the SRAM address {bank[4:0], A[13:0]}, where bank is the current bank register value.
- R2: A write to $0510 (direction low, data phase high) captures data bits [4:0] into the bank register at the clock edge, so bank values wrap modulo 32 and data bits [7:5] are dropped. The new bank is visible on the next access.
- R3: An access in $3800-$3FFF drives the SRAM address {8'hFF, A[10:0]}, independent of the bank register.
- R4: SRAM chip enable (active low) is asserted only when the address is in one of the two SRAM windows and the external RAM enable (active low) is asserted. Every other address keeps it high.
- R5: The sound select (active high) is asserted only when the address is in $0500-$050F and the external sound enable is high.
- R6: On a read (direction high) with chip enable asserted, output enable (active low) is asserted and write enable stays high.
- R7: Write enable (active low) is asserted only while chip enable is asserted, direction is low and the data phase is high. Output enable stays high on every write.
- R8: Reset (active low) clears the bank register to 0.
- R9: A read of $0510, or a write of $0510 outside the data phase, leaves the bank register unchanged. $0510 selects neither the SRAM nor the sound chip.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; the bank register samples on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_addr | input | 16 | Console address bus |
| cpu_rnw | input | 1 | Direction: 1 read, 0 write |
| cpu_phase | input | 1 | High while the data bus carries valid data |
| cpu_data | input | 8 | Console data bus, write data |
| ext_ram_en_n | input | 1 | External RAM enable from the second controller, active low |
| ext_snd_en | input | 1 | External sound enable from the second controller, active high |
| sram_addr | output | 19 | SRAM address |
| sram_ce_n | output | 1 | SRAM chip enable, active low |
| sram_oe_n | output | 1 | SRAM output enable, active low |
| sram_we_n | output | 1 | SRAM write enable, active low |
| snd_cs | output | 1 | Sound chip select, active high |

## Verification
Two things can meet in consecutive cycles: a bank register update and an access through the banked window. The bench writes a new bank at $0510 on one clock edge and, in the very next cycle, presents a banked address. It then requires the upper five SRAM address bits to carry the new value, not the old one. The bench also holds a $0510 write across an edge while the data phase is low, and a $0510 read across an edge. After each, a following banked access must show the previous bank unchanged.

// File: rtl/sram_win_pkg.sv
package sram_win_pkg;
  // window indices into the decode vector
  localparam int WIN_BANK = 0;
  localparam int WIN_FONT = 1;
  localparam int WIN_SND  = 2;
  localparam int WIN_BREG = 3;
  localparam int WIN_N    = 4;

  typedef logic [WIN_N-1:0] hit_vec_t;
endpackage

// File: rtl/sram_win_decode.sv
module sram_win_decode
  import sram_win_pkg::*;
#(
  parameter int          CPU_AW    = 16,
  parameter int          BANK_AW   = 14,
  parameter int          FONT_AW   = 11,
  parameter int          SND_AW    = 4,
  parameter logic [15:0] BANK_BASE = 16'h4000,
  parameter logic [15:0] FONT_BASE = 16'h3800,
  parameter logic [15:0] SND_BASE  = 16'h0500,
  parameter logic [15:0] BREG_ADDR = 16'h0510
) (
  input  logic [CPU_AW-1:0] addr,
  output hit_vec_t          hit
);
  // per-window size in address bits, and base address
  localparam int          WSZ  [WIN_N] = '{BANK_AW, FONT_AW, SND_AW, 0};
  localparam logic [15:0] WBASE[WIN_N] = '{BANK_BASE, FONT_BASE, SND_BASE, BREG_ADDR};

  for (genvar i = 0; i < WIN_N; i++) begin : g_win
    if (WSZ[i] == 0) begin : g_exact
      assign hit[i] = (addr == WBASE[i][CPU_AW-1:0]);
    end else begin : g_range
      assign hit[i] = (addr[CPU_AW-1:WSZ[i]] == WBASE[i][CPU_AW-1:WSZ[i]]);
    end
  end
endmodule

// File: rtl/sram_win_bankreg.sv
module sram_win_bankreg #(
  parameter int DATA_W = 8,
  parameter int BANK_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] din,
  output logic [BANK_W-1:0] bank
);
  // upper data bits carry no bank information; modulo wrap by truncation
  logic unused_hi;
  assign unused_hi = ^din[DATA_W-1:BANK_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     bank <= '0;
    else if (wr_en) bank <= din[BANK_W-1:0];
  end
endmodule

// File: rtl/sram_win_addrmux.sv
module sram_win_addrmux #(
  parameter int CPU_AW  = 16,
  parameter int SRAM_AW = 19,
  parameter int BANK_AW = 14,
  parameter int FONT_AW = 11
) (
  input  logic [CPU_AW-1:0]          addr,
  input  logic [SRAM_AW-BANK_AW-1:0] bank,
  input  logic                       font_sel,
  output logic [SRAM_AW-1:0]         sram_addr
);
  localparam int FONT_TOP_W = SRAM_AW - FONT_AW;

  logic [SRAM_AW-1:0] banked_a, font_a;
  logic               unused_hi;

  assign unused_hi = ^addr[CPU_AW-1:BANK_AW];
  assign banked_a  = {bank, addr[BANK_AW-1:0]};
  assign font_a    = {{FONT_TOP_W{1'b1}}, addr[FONT_AW-1:0]};
  assign sram_addr = font_sel ? font_a : banked_a;
endmodule

// File: rtl/sram_win_dec.sv
module sram_win_dec
  import sram_win_pkg::*;
#(
  parameter int CPU_AW  = 16,
  parameter int DATA_W  = 8,
  parameter int SRAM_AW = 19,
  parameter int BANK_AW = 14,
  parameter int FONT_AW = 11
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CPU_AW-1:0]  cpu_addr,
  input  logic               cpu_rnw,
  input  logic               cpu_phase,
  input  logic [DATA_W-1:0]  cpu_data,
  input  logic               ext_ram_en_n,
  input  logic               ext_snd_en,
  output logic [SRAM_AW-1:0] sram_addr,
  output logic               sram_ce_n,
  output logic               sram_oe_n,
  output logic               sram_we_n,
  output logic               snd_cs
);
  localparam int BANK_W = SRAM_AW - BANK_AW;

  hit_vec_t          hit;
  logic [BANK_W-1:0] bank;
  logic              ram_sel, bank_wr;

  sram_win_decode #(
    .CPU_AW (CPU_AW),
    .BANK_AW(BANK_AW),
    .FONT_AW(FONT_AW)
  ) u_decode (
    .addr(cpu_addr),
    .hit (hit)
  );

  assign bank_wr = hit[WIN_BREG] & ~cpu_rnw & cpu_phase;

  sram_win_bankreg #(
    .DATA_W(DATA_W),
    .BANK_W(BANK_W)
  ) u_bank (
    .clk  (clk),
    .rst_n(rst_n),
    .wr_en(bank_wr),
    .din  (cpu_data),
    .bank (bank)
  );

  sram_win_addrmux #(
    .CPU_AW (CPU_AW),
    .SRAM_AW(SRAM_AW),
    .BANK_AW(BANK_AW),
    .FONT_AW(FONT_AW)
  ) u_amux (
    .addr     (cpu_addr),
    .bank     (bank),
    .font_sel (hit[WIN_FONT]),
    .sram_addr(sram_addr)
  );

  // final selects: own decode AND external enable
  assign ram_sel   = (hit[WIN_BANK] | hit[WIN_FONT]) & ~ext_ram_en_n;
  assign sram_ce_n = ~ram_sel;
  assign sram_oe_n = ~(ram_sel & cpu_rnw);
  assign sram_we_n = ~(ram_sel & ~cpu_rnw & cpu_phase);
  assign snd_cs    = hit[WIN_SND] & ext_snd_en;
endmodule

// File: rtl/sram_win_dec_chk.sv
module sram_win_dec_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] cpu_addr,
  input logic        cpu_rnw,
  input logic        cpu_phase,
  input logic [7:0]  cpu_data,
  input logic        ext_ram_en_n,
  input logic        ext_snd_en,
  input logic [18:0] sram_addr,
  input logic        sram_ce_n,
  input logic        sram_oe_n,
  input logic        sram_we_n,
  input logic        snd_cs
);
  logic in_bank, in_font, in_snd, bank_write;
  assign in_bank    = (cpu_addr >= 16'h4000) && (cpu_addr <= 16'h7FFF);
  assign in_font    = (cpu_addr >= 16'h3800) && (cpu_addr <= 16'h3FFF);
  assign in_snd     = (cpu_addr >= 16'h0500) && (cpu_addr <= 16'h050F);
  assign bank_write = (cpu_addr == 16'h0510) && !cpu_rnw && cpu_phase;

  // R2: a bank write shows up on the next banked access
  a_r2_bank_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(bank_write) && in_bank |-> sram_addr[18:14] == $past(cpu_data[4:0]));

  // R3: font window points into the top 2K
  a_r3_font_top: assert property (@(posedge clk) disable iff (!rst_n)
    in_font |-> sram_addr[18:11] == 8'hFF);

  // R4: chip enable needs a window hit and the external enable
  a_r4_ce_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_ce_n |-> !ext_ram_en_n && (in_bank || in_font));

  // R5: sound select needs its range and its enable
  a_r5_snd_gated: assert property (@(posedge clk) disable iff (!rst_n)
    snd_cs |-> ext_snd_en && in_snd);

  // R6: strobes never overlap
  a_r6_oe_we_excl: assert property (@(posedge clk) disable iff (!rst_n)
    sram_oe_n || sram_we_n);

  // R7: write strobe only on a valid-phase write under chip enable
  a_r7_we_phase: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_we_n |-> !cpu_rnw && cpu_phase && !sram_ce_n);

  // R9: the bank register address selects no device
  a_r9_breg_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_addr == 16'h0510 |-> sram_ce_n && !snd_cs);
endmodule

bind sram_win_dec sram_win_dec_chk u_chk (.*);

// File: tb/sram_win_dec_tb_top.sv
module sram_win_dec_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = 16'hFFFF;
  logic        cpu_rnw = 1'b1;
  logic        cpu_phase = 1'b0;
  logic [7:0]  cpu_data = 8'h00;
  logic        ext_ram_en_n = 1'b0;
  logic        ext_snd_en = 1'b1;
  logic [18:0] sram_addr;
  logic        sram_ce_n, sram_oe_n, sram_we_n, snd_cs;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  sram_win_dec dut_i (.*);

  typedef struct packed {
    logic [15:0] addr;
    logic        rnw, ph, ramn, snd;
    logic        ce_n, oe_n, we_n, cs;
    logic [18:0] sa;
    logic        chk_sa;
  } vec_t;

  // bank register holds 5'h0A while this table runs
  localparam int NV = 13;
  localparam vec_t VEC [NV] = '{
    '{16'h4000, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 19'h28000, 1'b1}, // R1 R6
    '{16'h7FFF, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 19'h2BFFF, 1'b1}, // R1 R7
    '{16'h5123, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 19'h29123, 1'b1}, // R7 phase low
    '{16'h3800, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 19'h7F800, 1'b1}, // R3
    '{16'h3FFF, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 19'h7FFFF, 1'b1}, // R3 R7
    '{16'h37FF, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 19'h00000, 1'b0}, // R4
    '{16'h8000, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 19'h00000, 1'b0}, // R4
    '{16'h4000, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 19'h00000, 1'b0}, // R4 ext off
    '{16'h0500, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 19'h00000, 1'b0}, // R5
    '{16'h050F, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 19'h00000, 1'b0}, // R5
    '{16'h0510, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 19'h00000, 1'b0}, // R9
    '{16'h0505, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 19'h00000, 1'b0}, // R5 ext off
    '{16'h04FF, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 19'h00000, 1'b0}  // R5
  };

  task automatic check_sa(input string req, input logic [18:0] exp);
    checks++;
    if (sram_addr !== exp) begin
      fails++;
      $display("FAIL %s sram_addr actual=%h expected=%h", req, sram_addr, exp);
    end
  endtask

  task automatic bus(input logic [15:0] a, input logic rnw, input logic ph, input logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_rnw = rnw; cpu_phase = ph; cpu_data = d;
  endtask

  task automatic bank_write(input logic [7:0] d);
    bus(16'h0510, 1'b0, 1'b1, d);
    @(posedge clk);
    @(negedge clk);
    cpu_addr = 16'hFFFF; cpu_rnw = 1'b1; cpu_phase = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R8: bank 0 after reset
    bus(16'h4ABC, 1'b1, 1'b1, 8'h00); #1;
    check_sa("R8 reset bank", 19'h00ABC);

    // R2: new bank is used in the cycle right after the write edge
    bus(16'h0510, 1'b0, 1'b1, 8'h0A);
    @(posedge clk);
    bus(16'h4000, 1'b1, 1'b1, 8'h00); #1;
    check_sa("R2 bank update", 19'h28000);

    // table walk with bank 0x0A
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      cpu_addr = VEC[i].addr; cpu_rnw = VEC[i].rnw; cpu_phase = VEC[i].ph;
      ext_ram_en_n = VEC[i].ramn; ext_snd_en = VEC[i].snd;
      #1;
      checks++;
      if ({sram_ce_n, sram_oe_n, sram_we_n, snd_cs} !== {VEC[i].ce_n, VEC[i].oe_n, VEC[i].we_n, VEC[i].cs} ||
          (VEC[i].chk_sa && sram_addr !== VEC[i].sa)) begin
        fails++;
        $display("FAIL R1-table vec %0d ce/oe/we/cs actual=%b%b%b%b expected=%b%b%b%b addr actual=%h expected=%h",
                 i, sram_ce_n, sram_oe_n, sram_we_n, snd_cs,
                 VEC[i].ce_n, VEC[i].oe_n, VEC[i].we_n, VEC[i].cs, sram_addr, VEC[i].sa);
      end
    end
    ext_ram_en_n = 1'b0; ext_snd_en = 1'b1;

    // R9: phase-low write and a read of $0510 across edges leave the bank alone
    bus(16'h0510, 1'b0, 1'b0, 8'h1F); @(posedge clk);
    bus(16'h0510, 1'b1, 1'b1, 8'h13); @(posedge clk);
    bus(16'h4001, 1'b1, 1'b1, 8'h00); #1;
    check_sa("R9 bank unchanged", 19'h28001);

    // R2: data bits above the bank width are dropped (0x25 -> bank 5)
    bank_write(8'h25);
    bus(16'h4000, 1'b1, 1'b1, 8'h00); #1;
    check_sa("R2 modulo 32", 19'h14000);

    // R3: font window ignores the bank
    bus(16'h3C00, 1'b1, 1'b1, 8'h00); #1;
    check_sa("R3 font with bank 5", 19'h7FC00);

    // R1: top bank, top address
    bank_write(8'h1F);
    bus(16'h7FFF, 1'b1, 1'b1, 8'h00); #1;
    check_sa("R1 bank 31", 19'h7FFFF);

    // R8: reset in mid-run clears the bank
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk) rst_n = 1'b1;
    bus(16'h4010, 1'b1, 1'b1, 8'h00); #1;
    check_sa("R8 reset again", 19'h00010);
    checks++;
    if (sram_ce_n !== 1'b0 || sram_oe_n !== 1'b0) begin
      fails++;
      $display("FAIL R6 read strobes ce=%b oe=%b expected ce=0 oe=0", sram_ce_n, sram_oe_n);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule